// File: doc/BRIEF.md
# Counter Channel Host Byte Port

This block sits between an 8-bit host data bus and the 16-bit core of one counter channel. Every host access targets one of two locations. One is the command location, which carries a channel-select field and either a snapshot request or a new configuration. The other is the data location, through which the 16-bit reload value is written and the running count is read, one byte per access.

A single byte-order state machine is shared by reads and writes. While a two-byte reload is half written, it holds the counter core paused. When the reload is complete, it hands the assembled value to the core with a one-cycle strobe. A snapshot request freezes a copy of the live count, and that copy stays stable across the two byte reads that return it.

The state machine has four states. SEQ_LO means the next data access uses the low byte. SEQ_HI_RD means the low byte was just read. SEQ_HI_WR means the low reload byte was just written and the core is paused. SEQ_LO_PEND means a read moved the pointer back to low while a reload is still half written, and the core stays paused. The transitions are:
- A write in SEQ_LO or SEQ_LO_PEND goes to SEQ_HI_WR.
- A read in SEQ_LO goes to SEQ_HI_RD.
- A read in SEQ_LO_PEND goes to SEQ_HI_WR.
- Any access in SEQ_HI_RD returns to SEQ_LO.
- A write in SEQ_HI_WR returns to SEQ_LO.
- A read in SEQ_HI_WR goes to SEQ_LO_PEND.
- A configuration write forces SEQ_LO from any state.

The state machine moves only in two-byte access mode.

Top module: `ctp_host_port`

## Requirements
- R1: After reset, `hold_req`, `reload_stb`, `cfg_stb` and `rd_valid` are 0, `cfg_access` is 3 (two-byte), `cfg_mode` is 0, `cfg_bcd` is 0, and the byte pointer is at the low byte.
- R2: A command byte is ignored, with no configuration or pointer change and no snapshot, in two cases. The first is when bits 7:6 differ from `CHAN_ID`. The second is when bits 5:4 are 0 but bits 3:0 are not all 0.
- R3: A command byte with bits 7:6 equal to `CHAN_ID` and bits 5:0 all zero takes a snapshot of `live_count`. Data reads then return the snapshot instead of the live count, until the snapshot is released.
- R4: A second snapshot command, issued while a snapshot is still held, has no effect on the held value.
- R5: A command byte with bits 7:6 equal to `CHAN_ID` and bits 5:4 nonzero is a configuration write. It sets `cfg_access` to bits 5:4, `cfg_mode` to bits 3:1 and `cfg_bcd` to bit 0. It pulses `cfg_stb` for one cycle. It returns the pointer to low and drops any half-written reload and any held snapshot.
- R6: In two-byte access (`cfg_access` = 3), the first data write is the low byte and the second is the high byte. One cycle after the second write, `reload_stb` is 1 for one cycle with `reload_val` = {second, first}. The first write gives no strobe.
- R7: `hold_req` rises in the cycle after the first reload byte is written. It falls in the cycle `reload_stb` rises.
- R8: In low-only access (`cfg_access` = 1), each data write strobes `reload_val` = {8'h00, data}. In high-only access (`cfg_access` = 2), each data write strobes {data, 8'h00}. Neither mode raises `hold_req`.
- R9: In two-byte access, data reads return the low byte, then the high byte. `rd_data` is valid with `rd_valid` = 1 in the cycle after the read request.
- R10: The byte pointer is shared. A read that follows a first reload byte returns a high byte, the pause remains, and the next write is taken as a new low byte.
- R11: In low-only access, reads return bits 7:0. In high-only access, reads return bits 15:8. In both modes, a held snapshot is released by one read.
- R12: A read of the command location produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write request |
| bus_rd | input | 1 | Host read request |
| bus_cmd | input | 1 | 1 selects the command location, 0 selects the data location |
| bus_wdata | input | 8 | Host write byte |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | `rd_data` is valid |
| live_count | input | 16 | Running count from the counter core |
| reload_val | output | 16 | Assembled reload value |
| reload_stb | output | 1 | Reload value complete |
| hold_req | output | 1 | Pause request while a reload is half written |
| cfg_access | output | 2 | Access mode |
| cfg_mode | output | 3 | Counting mode number for the core |
| cfg_bcd | output | 1 | Decimal counting select for the core |
| cfg_stb | output | 1 | Configuration was written |

## Verification
The assertions assume the host never raises a read and a write in the same cycle, and that the bus inputs are 0 during reset. The driver tasks issue exactly one access per transaction and park all strobes low between accesses. They also assume `live_count` changes only between accesses, so a snapshot and a read see a settled value; the bench changes it only while the bus is idle.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
    localparam int BYTE_W  = 8;
    localparam int COUNT_W = 2 * BYTE_W;
    localparam int MODE_W  = 3;

    typedef enum logic [1:0] {
        ACC_SNAP = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_BOTH = 2'b11
    } access_e;

    typedef enum logic [1:0] {
        SEQ_LO      = 2'b00,
        SEQ_HI_RD   = 2'b01,
        SEQ_HI_WR   = 2'b10,
        SEQ_LO_PEND = 2'b11
    } seq_e;
endpackage

// File: rtl/ctp_cmd_decode.sv
module ctp_cmd_decode
    import ctp_pkg::*;
#(
    parameter int CHAN_W  = 2,
    parameter int CHAN_ID = 0
) (
    input  logic              cmd_wr,
    input  logic [BYTE_W-1:0] cmd_byte,
    output logic              snap_cmd,
    output logic              cfg_wr,
    output access_e           cfg_acc_new,
    output logic [MODE_W-1:0] cfg_mode_new,
    output logic              cfg_bcd_new
);
    localparam int SEL_LSB = BYTE_W - CHAN_W;

    logic ours;
    logic acc_zero;
    logic low_zero;

    always_comb begin
        ours         = (cmd_byte[BYTE_W-1:SEL_LSB] == CHAN_W'(CHAN_ID));
        acc_zero     = (cmd_byte[5:4] == 2'b00);
        low_zero     = (cmd_byte[3:0] == 4'h0);
        snap_cmd     = cmd_wr && ours && acc_zero && low_zero;
        cfg_wr       = cmd_wr && ours && !acc_zero;
        cfg_acc_new  = access_e'(cmd_byte[5:4]);
        cfg_mode_new = cmd_byte[3:1];
        cfg_bcd_new  = cmd_byte[0];
    end
endmodule

// File: rtl/ctp_byte_seq.sv
module ctp_byte_seq
    import ctp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seq_clr,
    input  logic two_byte,
    input  logic data_wr,
    input  logic data_rd,
    output logic ptr_hi,
    output logic hold
);
    seq_e state_q;
    seq_e state_d;

    always_comb begin
        state_d = state_q;
        if (seq_clr) begin
            state_d = SEQ_LO;
        end else if (two_byte && (data_wr || data_rd)) begin
            unique case (state_q)
                SEQ_LO:      state_d = data_wr ? SEQ_HI_WR : SEQ_HI_RD;
                SEQ_HI_RD:   state_d = SEQ_LO;
                SEQ_HI_WR:   state_d = data_wr ? SEQ_LO : SEQ_LO_PEND;
                SEQ_LO_PEND: state_d = SEQ_HI_WR;
                default:     state_d = SEQ_LO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_LO;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ptr_hi = 1'b0;
        hold   = 1'b0;
        unique case (state_q)
            SEQ_LO:      begin ptr_hi = 1'b0; hold = 1'b0; end
            SEQ_HI_RD:   begin ptr_hi = 1'b1; hold = 1'b0; end
            SEQ_HI_WR:   begin ptr_hi = 1'b1; hold = 1'b1; end
            SEQ_LO_PEND: begin ptr_hi = 1'b0; hold = 1'b1; end
            default:     begin ptr_hi = 1'b0; hold = 1'b0; end
        endcase
    end

    AST_HOLD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $past(data_wr)); // R7

    AST_CLR_DROPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        seq_clr |=> (!hold && !ptr_hi)); // R5

    AST_SINGLE_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!two_byte && !hold) |=> !hold); // R8
endmodule

// File: rtl/ctp_reload_asm.sv
module ctp_reload_asm
    import ctp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               data_wr,
    input  access_e            acc,
    input  logic               ptr_hi,
    input  logic [BYTE_W-1:0]  wdata,
    output logic [COUNT_W-1:0] reload_val,
    output logic               reload_stb
);
    logic [BYTE_W-1:0]  lo_stage_q;
    logic [COUNT_W-1:0] val_d;
    logic               stb_d;
    logic               stage_ld;

    always_comb begin
        val_d    = reload_val;
        stb_d    = 1'b0;
        stage_ld = 1'b0;
        if (data_wr) begin
            unique case (acc)
                ACC_LO: begin
                    val_d = {{BYTE_W{1'b0}}, wdata};
                    stb_d = 1'b1;
                end
                ACC_HI: begin
                    val_d = {wdata, {BYTE_W{1'b0}}};
                    stb_d = 1'b1;
                end
                ACC_BOTH: begin
                    if (ptr_hi) begin
                        val_d = {wdata, lo_stage_q};
                        stb_d = 1'b1;
                    end else begin
                        stage_ld = 1'b1;
                    end
                end
                default: begin
                    stb_d = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_stage_q <= '0;
            reload_val <= '0;
            reload_stb <= 1'b0;
        end else begin
            if (stage_ld) begin
                lo_stage_q <= wdata;
            end
            reload_val <= val_d;
            reload_stb <= stb_d;
        end
    end

    AST_STB_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reload_stb |-> $past(data_wr)); // R6

    AST_VAL_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(data_wr) |-> $stable(reload_val)); // R6
endmodule

// File: rtl/ctp_snap_latch.sv
module ctp_snap_latch
    import ctp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               snap_cmd,
    input  logic               snap_clr,
    input  logic               snap_rel,
    input  logic [COUNT_W-1:0] live,
    output logic               held,
    output logic [COUNT_W-1:0] snap
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
            snap <= '0;
        end else if (snap_clr) begin
            held <= 1'b0;
        end else if (snap_cmd && !held) begin
            held <= 1'b1;
            snap <= live;
        end else if (snap_rel) begin
            held <= 1'b0;
        end
    end

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held)) |-> $stable(snap)); // R4

    AST_SNAP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $past(snap_cmd)); // R3
endmodule

// File: rtl/ctp_host_port.sv
module ctp_host_port
    import ctp_pkg::*;
#(
    parameter int CHAN_W  = 2,
    parameter int CHAN_ID = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_cmd,
    input  logic [BYTE_W-1:0]  bus_wdata,
    output logic [BYTE_W-1:0]  rd_data,
    output logic               rd_valid,
    input  logic [COUNT_W-1:0] live_count,
    output logic [COUNT_W-1:0] reload_val,
    output logic               reload_stb,
    output logic               hold_req,
    output logic [1:0]         cfg_access,
    output logic [MODE_W-1:0]  cfg_mode,
    output logic               cfg_bcd,
    output logic               cfg_stb
);
    logic              cmd_wr;
    logic              data_wr;
    logic              data_rd;
    logic              snap_cmd;
    logic              cfg_wr;
    access_e           acc_new;
    logic [MODE_W-1:0] mode_new;
    logic              bcd_new;
    access_e           acc_q;
    logic              ptr_hi;
    logic              held;
    logic [COUNT_W-1:0] snap;
    logic              snap_rel;
    logic              sel_hi;
    logic [COUNT_W-1:0] src;

    always_comb begin
        cmd_wr  = bus_wr && bus_cmd;
        data_wr = bus_wr && !bus_cmd;
        data_rd = bus_rd && !bus_cmd && !bus_wr;
    end

    ctp_cmd_decode #(
        .CHAN_W  (CHAN_W),
        .CHAN_ID (CHAN_ID)
    ) i_dec (
        .cmd_wr      (cmd_wr),
        .cmd_byte    (bus_wdata),
        .snap_cmd    (snap_cmd),
        .cfg_wr      (cfg_wr),
        .cfg_acc_new (acc_new),
        .cfg_mode_new(mode_new),
        .cfg_bcd_new (bcd_new)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= ACC_BOTH;
            cfg_mode <= '0;
            cfg_bcd  <= 1'b0;
            cfg_stb  <= 1'b0;
        end else begin
            cfg_stb <= cfg_wr;
            if (cfg_wr) begin
                acc_q    <= acc_new;
                cfg_mode <= mode_new;
                cfg_bcd  <= bcd_new;
            end
        end
    end

    assign cfg_access = acc_q;

    ctp_byte_seq i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .seq_clr (cfg_wr),
        .two_byte(acc_q == ACC_BOTH),
        .data_wr (data_wr),
        .data_rd (data_rd),
        .ptr_hi  (ptr_hi),
        .hold    (hold_req)
    );

    ctp_reload_asm i_rl (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (data_wr),
        .acc       (acc_q),
        .ptr_hi    (ptr_hi),
        .wdata     (bus_wdata),
        .reload_val(reload_val),
        .reload_stb(reload_stb)
    );

    always_comb begin
        unique case (acc_q)
            ACC_LO:   sel_hi = 1'b0;
            ACC_HI:   sel_hi = 1'b1;
            default:  sel_hi = ptr_hi;
        endcase
        snap_rel = data_rd && held && ((acc_q != ACC_BOTH) || ptr_hi);
        src      = held ? snap : live_count;
    end

    ctp_snap_latch i_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .snap_cmd(snap_cmd),
        .snap_clr(cfg_wr),
        .snap_rel(snap_rel),
        .live    (live_count),
        .held    (held),
        .snap    (snap)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= data_rd;
            if (data_rd) begin
                rd_data <= sel_hi ? src[COUNT_W-1:BYTE_W] : src[BYTE_W-1:0];
            end
        end
    end

    AST_RD_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_rd && !bus_cmd)); // R12

    AST_STB_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        reload_stb |-> !hold_req); // R7

    AST_CFG_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_stb |-> $past(bus_wr && bus_cmd)); // R5
endmodule

// File: tb/test_ctp_host_port.sv
module test_ctp_host_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_cmd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [15:0] live_count = 16'h0000;
    logic [15:0] reload_val;
    logic        reload_stb;
    logic        hold_req;
    logic [1:0]  cfg_access;
    logic [2:0]  cfg_mode;
    logic        cfg_bcd;
    logic        cfg_stb;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0]  exp_rd_q[$];
    string       rd_tag_q[$];
    logic [15:0] exp_rl_q[$];
    string       rl_tag_q[$];

    always #4 clk = ~clk;

    ctp_host_port #(.CHAN_W(2), .CHAN_ID(0)) i_ctp_host_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_cmd(bus_cmd), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .live_count(live_count), .reload_val(reload_val),
        .reload_stb(reload_stb), .hold_req(hold_req), .cfg_access(cfg_access),
        .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd), .cfg_stb(cfg_stb)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read bytes and reload values
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (exp_rd_q.size() == 0) begin
                    chk("R12 unexpected read data", 1, 0);
                end else begin
                    chk(rd_tag_q.pop_front(), int'(rd_data), int'(exp_rd_q.pop_front()));
                end
            end
            if (reload_stb) begin
                if (exp_rl_q.size() == 0) begin
                    chk("R6 unexpected reload strobe", 1, 0);
                end else begin
                    chk(rl_tag_q.pop_front(), int'(reload_val), int'(exp_rl_q.pop_front()));
                end
            end
        end
    end

    task automatic bus_write(input logic cmd, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_cmd = cmd; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_cmd = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] d, input logic [15:0] exp, input string tag, input bit expect_stb);
        if (expect_stb) begin
            exp_rl_q.push_back(exp);
            rl_tag_q.push_back(tag);
        end
        bus_write(1'b0, d);
    endtask

    task automatic rd_data_exp(input logic [7:0] exp, input string tag);
        exp_rd_q.push_back(exp);
        rd_tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_cmd = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 hold_req", hold_req, 0);
        chk("R1 reload_stb", reload_stb, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 cfg_stb", cfg_stb, 0);
        chk("R1 cfg_access", cfg_access, 3);
        chk("R1 cfg_mode", cfg_mode, 0);
        chk("R1 cfg_bcd", cfg_bcd, 0);

        // R5 configuration write 0x35: access 3, mode 2, bcd 1
        @(negedge clk);
        bus_wr = 1'b1; bus_cmd = 1'b1; bus_wdata = 8'h35;
        @(negedge clk);
        bus_wr = 1'b0; bus_cmd = 1'b0;
        chk("R5 cfg_stb", cfg_stb, 1);
        chk("R5 cfg_access", cfg_access, 3);
        chk("R5 cfg_mode", cfg_mode, 2);
        chk("R5 cfg_bcd", cfg_bcd, 1);
        @(negedge clk);
        chk("R5 cfg_stb one cycle", cfg_stb, 0);

        // R2 foreign channel and malformed snapshot commands ignored
        bus_write(1'b1, 8'h72);
        chk("R2 foreign cfg_mode", cfg_mode, 2);
        chk("R2 foreign cfg_bcd", cfg_bcd, 1);
        live_count = 16'h2468;
        bus_write(1'b1, 8'h40);
        bus_write(1'b1, 8'h04);
        live_count = 16'h1357;
        rd_data_exp(8'h57, "R2 no snapshot low");
        rd_data_exp(8'h13, "R2 no snapshot high");

        // R6 R7 two-byte reload
        wr_data(8'h34, 16'h0, "", 1'b0);
        chk("R7 hold after first byte", hold_req, 1);
        wr_data(8'h12, 16'h1234, "R6 reload 1234", 1'b1);
        chk("R7 hold released", hold_req, 0);

        // R9 live reads low then high
        live_count = 16'hABCD;
        rd_data_exp(8'hCD, "R9 live low");
        live_count = 16'h1111;
        rd_data_exp(8'h11, "R9 live high");

        // R3 R4 snapshot, second snapshot ignored
        live_count = 16'h5678;
        bus_write(1'b1, 8'h00);
        live_count = 16'h9999;
        rd_data_exp(8'h78, "R3 snapshot low");
        live_count = 16'h4444;
        bus_write(1'b1, 8'h00);
        rd_data_exp(8'h56, "R4 snapshot high kept");
        live_count = 16'h4321;
        rd_data_exp(8'h21, "R3 released low");
        rd_data_exp(8'h43, "R3 released high");

        // R10 shared pointer
        live_count = 16'h7F00;
        wr_data(8'hAA, 16'h0, "", 1'b0);
        rd_data_exp(8'h7F, "R10 read after low write gives high");
        chk("R10 hold kept", hold_req, 1);
        wr_data(8'hBB, 16'h0, "", 1'b0);
        chk("R10 hold still", hold_req, 1);
        wr_data(8'hCC, 16'hCCBB, "R10 reload CCBB", 1'b1);
        chk("R10 hold dropped", hold_req, 0);

        // R5 configuration write cancels half reload and snapshot
        wr_data(8'h11, 16'h0, "", 1'b0);
        chk("R5 hold before cfg", hold_req, 1);
        bus_write(1'b1, 8'h34);
        chk("R5 hold cleared", hold_req, 0);
        wr_data(8'h22, 16'h0, "", 1'b0);
        wr_data(8'h33, 16'h3322, "R5 reload after cfg", 1'b1);
        live_count = 16'h0102;
        bus_write(1'b1, 8'h00);
        bus_write(1'b1, 8'h34);
        live_count = 16'h0304;
        rd_data_exp(8'h04, "R5 snapshot dropped low");
        rd_data_exp(8'h03, "R5 snapshot dropped high");

        // R8 R11 low-only
        bus_write(1'b1, 8'h10);
        chk("R8 access low-only", cfg_access, 1);
        wr_data(8'h5A, 16'h005A, "R8 low-only 5A", 1'b1);
        chk("R8 no hold", hold_req, 0);
        wr_data(8'h5B, 16'h005B, "R8 low-only 5B", 1'b1);
        live_count = 16'hBEEF;
        rd_data_exp(8'hEF, "R11 low-only read");
        rd_data_exp(8'hEF, "R11 low-only read again");
        live_count = 16'h1357;
        bus_write(1'b1, 8'h00);
        live_count = 16'hBEEF;
        rd_data_exp(8'h57, "R11 low-only snapshot");
        rd_data_exp(8'hEF, "R11 low-only released");

        // R8 R11 high-only
        bus_write(1'b1, 8'h20);
        wr_data(8'h66, 16'h6600, "R8 high-only 66", 1'b1);
        chk("R8 no hold high-only", hold_req, 0);
        rd_data_exp(8'hBE, "R11 high-only read");
        live_count = 16'h2468;
        bus_write(1'b1, 8'h00);
        live_count = 16'hBEEF;
        rd_data_exp(8'h24, "R11 high-only snapshot");
        rd_data_exp(8'hBE, "R11 high-only released");

        // R12 command location read ignored
        @(negedge clk);
        bus_rd = 1'b1; bus_cmd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_cmd = 1'b0;
        chk("R12 no rd_valid", rd_valid, 0);

        repeat (3) @(negedge clk);
        chk("R9 all reads seen", exp_rd_q.size(), 0);
        chk("R6 all reloads seen", exp_rl_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule